// File: doc/BRIEF.md
# Password-Gated Serial Command Sequencer

This block is the byte-level protocol engine of a password-protected two-wire serial memory. A bit-level front end hands it bus start and stop events and each received byte. For every byte the sequencer returns an acknowledge decision, and while a read is open it offers array data back to the front end. Each session begins with a command byte and an eight-byte password. The password is checked against the register that the command selects. A self-timed busy period always follows the password. After it, the master sends the polling byte F0h, and the answer to that byte shows whether access was granted. Granted sessions then take a two-byte address and run a sector write, a sequential or random read, or a password change.

There are two storage arrays: a large array 0 with `A0_AW` address bits and a small array 1 with `A1_AW` address bits. Five 64-bit passwords guard them: read 0, read 1, write 0, write 1 and reset. All storage is plain registers. The nonvolatile cycle is a counter `BUSY_CYC` clocks long. Incoming bytes come as a valid-only stream with no back-pressure. The front end must take each acknowledge one cycle after the byte and must serialise bytes no faster than one per cycle. Read data uses valid/ready. `out_data` stays stable while `out_valid` is high. A cycle with `out_ready` high marks the byte as sent and acknowledged by the master, and the address advances. When both arrive in the same cycle, stop takes priority over start, and start takes priority over a byte.

Top module: `pwseq_top`

## Requirements
- R1: After reset no acknowledge or read data is offered, the block is not busy, and every password is zero.
- R2: These command bytes are acknowledged when not busy: 80h/88h read array 0/1; 90h/98h write array 0/1; A0h/A8h/B0h/B8h/C0h change the read 0, read 1, write 0, write 1 or reset password; E0h clears everything; E8h is a device reset; F0h polls. Any other byte is NACKed and returns the block to standby. In standby every byte is NACKed until a start arrives.
- R3: The eight bytes after a non-poll command are all ACKed and form the password, first byte most significant. Read commands use the read password of their array. Writes and changes use the password they name. E0h, E8h and C0h use the reset password.
- R4: While busy, any command byte other than F0h is NACKed, and a pending password result is kept.
- R5: The eighth password byte starts a busy period of `BUSY_CYC` cycles, whether or not the password matched.
- R6: An F0h byte is NACKed while busy. After busy it is ACKed if nothing is pending or if the pending password matched. A pending mismatch gives a NACK and clears the pending result.
- R7: After a granted poll, an address high byte and then a low byte are ACKed. The address keeps the low `A0_AW` bits for array 0 and the low `A1_AW` bits for array 1.
- R8: A sector write ACKs up to `SECTOR` data bytes and NACKs any further byte. A stop then writes the bytes to consecutive addresses, wrapping inside the array, and starts a busy period.
- R9: A start or stop during command, password, address, data or new-password input abandons the operation. It writes nothing and starts no busy period.
- R10: A sequential read returns consecutive bytes. Array 0 wraps from its last address to 0, and array 1 wraps from 1Fh to 0 by default (its last address).
- R11: A start inside an open read takes the next byte as a new low address byte. Array 0 keeps its upper address bits; array 1 is fully addressed by that byte.
- R12: A password change takes two zero address bytes and then the new value twice. On a stop, matching copies are stored and start a busy period. Mismatching copies leave the password unchanged and start no busy period.
- R13: A granted E0h poll clears both arrays and sets all passwords to zero. A granted E8h poll changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | Bus start (or repeated start) event, one-cycle pulse |
| ev_stop | input | 1 | Bus stop event, one-cycle pulse |
| in_valid | input | 1 | A received byte is present on in_data |
| in_data | input | 8 | Received byte |
| ack_valid | output | 1 | Acknowledge decision for the byte of the previous cycle |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK (meaningful with ack_valid) |
| out_valid | output | 1 | Read data byte available |
| out_ready | input | 1 | Front end consumed out_data and the master acknowledged it |
| out_data | output | 8 | Read data byte |

## Verification
The bench sweeps all 256 first bytes after a start. A decoder that misses or invents an opcode shows up as a wrong acknowledge. Every session polls once while busy and once after, so a design that leaks the password result early, or grants a wrong password, answers a poll wrongly. Writes and reads start near the end of each array, so a counter with the wrong width or wrap corrupts data readback. Aborted writes, an interrupted password, mismatched new-password copies and the clear command are each followed by a readback or poll. That readback or poll exposes any write, busy period or password change that should not have happened.

// File: rtl/pwseq_pkg.sv
package pwseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_PWD, S_WAIT, S_ADRH, S_ADRL,
    S_WDATA, S_RDATA, S_RADDR, S_NEW1, S_NEW2, S_NEWEND
  } state_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_RD, OP_WR, OP_CHG, OP_CLRALL, OP_DEVRST
  } op_t;

  typedef enum logic [2:0] {
    PW_RD0, PW_RD1, PW_WR0, PW_WR1, PW_RST
  } pwsel_t;

  localparam int NUM_PW = 5;
  localparam logic [7:0] POLL_CODE = 8'hF0;

  typedef struct packed {
    logic   legal;
    op_t    op;
    logic   arr;
    pwsel_t sel;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [7:0] b);
    cmd_t d;
    d.legal = 1'b1;
    d.op    = OP_NONE;
    d.arr   = 1'b0;
    d.sel   = PW_RST;
    case (b)
      8'h80: begin d.op = OP_RD;     d.sel = PW_RD0; end
      8'h88: begin d.op = OP_RD;     d.sel = PW_RD1; d.arr = 1'b1; end
      8'h90: begin d.op = OP_WR;     d.sel = PW_WR0; end
      8'h98: begin d.op = OP_WR;     d.sel = PW_WR1; d.arr = 1'b1; end
      8'hA0: begin d.op = OP_CHG;    d.sel = PW_RD0; end
      8'hA8: begin d.op = OP_CHG;    d.sel = PW_RD1; end
      8'hB0: begin d.op = OP_CHG;    d.sel = PW_WR0; end
      8'hB8: begin d.op = OP_CHG;    d.sel = PW_WR1; end
      8'hC0: begin d.op = OP_CHG;    d.sel = PW_RST; end
      8'hE0: begin d.op = OP_CLRALL; d.sel = PW_RST; end
      8'hE8: begin d.op = OP_DEVRST; d.sel = PW_RST; end
      default: d.legal = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pwseq_busy_timer.sv
module pwseq_busy_timer #(
  parameter int BUSY_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R5: a launch always yields a busy period
  p_launch_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/pwseq_pwbank.sv
module pwseq_pwbank
  import pwseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        we,
  input  pwsel_t      wsel,
  input  logic [63:0] wdata,
  input  pwsel_t      rsel,
  output logic [63:0] rdata
);
  logic [63:0] pw_q [NUM_PW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PW; i++) pw_q[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < NUM_PW; i++) pw_q[i] <= '0;
    end else if (we) begin
      pw_q[wsel] <= wdata;
    end
  end

  assign rdata = pw_q[rsel];

  for (genvar g = 0; g < NUM_PW; g++) begin : g_chk
    // R13: clearing zeroes every password
    p_clr_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pw_q[g] == 64'd0));
  end

endmodule

// File: rtl/pwseq_mem.sv
module pwseq_mem #(
  parameter int A0_AW = 10,
  parameter int A1_AW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic             wsel,
  input  logic [A0_AW-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic             rsel,
  input  logic [A0_AW-1:0] raddr,
  output logic [7:0]       rdata
);
  localparam int D0 = 1 << A0_AW;
  localparam int D1 = 1 << A1_AW;

  logic [7:0] arr0 [D0];
  logic [7:0] arr1 [D1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < D0; i++) arr0[i] <= '0;
    end else if (we && !wsel) begin
      arr0[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < D1; i++) arr1[i] <= '0;
    end else if (we && wsel) begin
      arr1[waddr[A1_AW-1:0]] <= wdata;
    end
  end

  assign rdata = rsel ? arr1[raddr[A1_AW-1:0]] : arr0[raddr];

  // R10: addresses into the small array never carry upper bits
  p_arr1_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wsel) |-> ((waddr >> A1_AW) == '0));

endmodule

// File: rtl/pwseq_top.sv
module pwseq_top
  import pwseq_pkg::*;
#(
  parameter int A0_AW    = 10,
  parameter int A1_AW    = 5,
  parameter int SECTOR   = 32,
  parameter int BUSY_CYC = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       ack_valid,
  output logic       ack_ok,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  localparam int IW = $clog2(SECTOR);
  localparam int SW = $clog2(SECTOR + 1);
  localparam logic [SW-1:0]    SEC_V   = SW'(SECTOR);
  localparam logic [A0_AW-1:0] A1_MASK = A0_AW'((1 << A1_AW) - 1);

  function automatic logic [A0_AW-1:0] fit(input logic arr, input logic [A0_AW-1:0] v);
    return arr ? (v & A1_MASK) : v;
  endfunction

  state_t st;
  op_t    cur_op, pend_op;
  logic   cur_arr, pend_arr;
  pwsel_t cur_sel, pend_sel;
  logic   pw_ok;
  logic [2:0]       pcnt;
  logic [63:0]      shift_q, new_q;
  logic [7:0]       addr_hi;
  logic [A0_AW-1:0] addr;
  logic [SW-1:0]    wcnt;
  logic [7:0]       sbuf [SECTOR];
  logic             clr_all;

  logic             wr_act, wr_arr;
  logic [SW-1:0]    wr_idx, wr_n;
  logic [A0_AW-1:0] wr_base;

  logic        busy, busy_start, byte_ev, pw_we, wr_launch, pw_done;
  logic [63:0] pw_cur, shift_nx;
  logic [7:0]  mem_rdata;
  logic [A0_AW-1:0] mem_waddr, raddr_new;
  cmd_t dec;

  assign byte_ev   = in_valid && !ev_start && !ev_stop;
  assign shift_nx  = {shift_q[55:0], in_data};
  assign dec       = decode_cmd(in_data);
  assign pw_done   = byte_ev && (st == S_PWD) && (pcnt == 3'd7);
  assign wr_launch = ev_stop && (st == S_WDATA) && (wcnt != '0);
  assign pw_we     = ev_stop && (st == S_NEWEND) && (new_q == shift_q);
  assign busy_start = pw_done || wr_launch || pw_we;
  assign raddr_new = fit(cur_arr, A0_AW'(({{(16-A0_AW){1'b0}}, addr} & 16'hFF00) | {8'h00, in_data}));
  assign mem_waddr = fit(wr_arr, wr_base + A0_AW'(wr_idx));

  pwseq_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(busy_start), .busy(busy)
  );

  pwseq_pwbank u_pw (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .we(pw_we), .wsel(cur_sel),
    .wdata(new_q), .rsel(cur_sel), .rdata(pw_cur)
  );

  pwseq_mem #(.A0_AW(A0_AW), .A1_AW(A1_AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .we(wr_act), .wsel(wr_arr),
    .waddr(mem_waddr), .wdata(sbuf[wr_idx[IW-1:0]]), .rsel(cur_arr),
    .raddr(addr), .rdata(mem_rdata)
  );

  assign out_valid = (st == S_RDATA);
  assign out_data  = mem_rdata;

  // sector drain: one buffered byte per cycle inside the busy period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act <= 1'b0; wr_arr <= 1'b0; wr_idx <= '0; wr_n <= '0; wr_base <= '0;
    end else if (wr_launch) begin
      wr_act <= 1'b1; wr_arr <= cur_arr; wr_idx <= '0; wr_n <= wcnt; wr_base <= addr;
    end else if (wr_act) begin
      wr_idx <= wr_idx + 1'b1;
      if (wr_idx == wr_n - 1'b1) wr_act <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (byte_ev && st == S_WDATA && wcnt < SEC_V) sbuf[wcnt[IW-1:0]] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur_op <= OP_NONE; pend_op <= OP_NONE;
      cur_arr <= 1'b0; pend_arr <= 1'b0; cur_sel <= PW_RD0; pend_sel <= PW_RD0;
      pw_ok <= 1'b0; pcnt <= '0; shift_q <= '0; new_q <= '0;
      addr_hi <= '0; addr <= '0; wcnt <= '0; clr_all <= 1'b0;
      ack_valid <= 1'b0; ack_ok <= 1'b0;
    end else begin
      ack_valid <= 1'b0;
      ack_ok    <= 1'b0;
      clr_all   <= 1'b0;
      if (ev_stop) begin
        st <= S_IDLE;
      end else if (ev_start) begin
        st <= (st == S_RDATA) ? S_RADDR : S_CMD;
      end else if (in_valid) begin
        ack_valid <= 1'b1;
        case (st)
          S_CMD: begin
            st <= S_IDLE;
            if (in_data == POLL_CODE) begin
              if (!busy) begin
                if (pend_op == OP_NONE) begin
                  ack_ok <= 1'b1;
                end else if (pw_ok) begin
                  ack_ok  <= 1'b1;
                  pend_op <= OP_NONE;
                  cur_op  <= pend_op;
                  cur_arr <= pend_arr;
                  cur_sel <= pend_sel;
                  if (pend_op == OP_RD || pend_op == OP_WR || pend_op == OP_CHG) st <= S_ADRH;
                  if (pend_op == OP_CLRALL) clr_all <= 1'b1;
                end else begin
                  pend_op <= OP_NONE;
                end
              end
            end else if (!busy && dec.legal) begin
              ack_ok  <= 1'b1;
              pend_op <= OP_NONE;
              cur_op  <= dec.op;
              cur_arr <= dec.arr;
              cur_sel <= dec.sel;
              pcnt    <= '0;
              st      <= S_PWD;
            end
          end
          S_PWD: begin
            ack_ok  <= 1'b1;
            shift_q <= shift_nx;
            pcnt    <= pcnt + 1'b1;
            if (pcnt == 3'd7) begin
              pend_op  <= cur_op;
              pend_arr <= cur_arr;
              pend_sel <= cur_sel;
              pw_ok    <= (shift_nx == pw_cur);
              st       <= S_WAIT;
            end
          end
          S_ADRH: begin
            ack_ok <= 1'b1; addr_hi <= in_data; st <= S_ADRL;
          end
          S_ADRL: begin
            ack_ok <= 1'b1;
            addr   <= fit(cur_arr, A0_AW'({addr_hi, in_data}));
            wcnt   <= '0;
            pcnt   <= '0;
            case (cur_op)
              OP_RD:   st <= S_RDATA;
              OP_WR:   st <= S_WDATA;
              default: st <= S_NEW1;
            endcase
          end
          S_WDATA: begin
            if (wcnt < SEC_V) begin
              ack_ok <= 1'b1; wcnt <= wcnt + 1'b1;
            end
          end
          S_RADDR: begin
            ack_ok <= 1'b1; addr <= raddr_new; st <= S_RDATA;
          end
          S_NEW1: begin
            ack_ok <= 1'b1; new_q <= {new_q[55:0], in_data}; pcnt <= pcnt + 1'b1;
            if (pcnt == 3'd7) st <= S_NEW2;
          end
          S_NEW2: begin
            ack_ok <= 1'b1; shift_q <= shift_nx; pcnt <= pcnt + 1'b1;
            if (pcnt == 3'd7) st <= S_NEWEND;
          end
          default: ;
        endcase
      end else if (out_ready && st == S_RDATA) begin
        addr <= fit(cur_arr, addr + 1'b1);
      end
    end
  end

  // R4: a non-poll command during busy is refused
  p_nack_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ev && st == S_CMD && busy && in_data != POLL_CODE) |=> (ack_valid && !ack_ok));

  // R6: a poll while busy is never granted
  p_poll_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ev && st == S_CMD && busy && in_data == POLL_CODE) |=> !ack_ok);

  // R8: array updates only happen inside a busy period
  p_write_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act |-> busy);

  // R2: every acknowledge answers a byte of the previous cycle
  p_ack_follows_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(in_valid));

  // R9: a stop during password entry abandons the session
  p_stop_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && st == S_PWD) |=> (st == S_IDLE && !busy));

endmodule

// File: tb/pwseq_top_bench.sv
module pwseq_top_bench;
  localparam int A0 = 10, A1 = 5, SEC = 32, BUSY = 40;
  localparam int D0 = 1 << A0, D1 = 1 << A1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_start = 1'b0, ev_stop = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic ack_valid, ack_ok, out_valid;
  logic [7:0] out_data;

  int nvec = 0, nbad = 0;
  logic done = 1'b0;
  logic [7:0] m0 [D0];
  logic [7:0] m1 [D1];

  always #5 clk = ~clk;

  pwseq_top #(.A0_AW(A0), .A1_AW(A1), .SECTOR(SEC), .BUSY_CYC(BUSY)) u_pwseq_top (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .in_valid(in_valid), .in_data(in_data), .ack_valid(ack_valid), .ack_ok(ack_ok),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_start();
    ev_start = 1'b1; @(negedge clk); ev_start = 1'b0;
  endtask

  task automatic do_stop();
    ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic exp, input string tag);
    in_valid = 1'b1; in_data = b; @(negedge clk); in_valid = 1'b0;
    chk(tag, {14'd0, ack_valid, ack_ok}, {14'd0, 1'b1, exp});
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    chk(tag, {7'd0, out_valid, out_data}, {7'd0, 1'b1, exp});
    out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic wait_busy();
    repeat (BUSY + 4) @(negedge clk);
  endtask

  task automatic send_pw(input logic [63:0] pw, input string tag);
    for (int i = 0; i < 8; i++) send(pw[63-8*i -: 8], 1'b1, tag);
  endtask

  // command, password, busy-time probes, then the deciding poll
  task automatic open_op(input logic [7:0] cmd, input logic [63:0] pw, input logic exp_poll);
    do_start();
    send(cmd, 1'b1, "R2 command");
    send_pw(pw, "R3 password byte");
    do_stop();
    do_start();
    send(8'h88, 1'b0, "R4 command while busy");
    do_start();
    send(8'hF0, 1'b0, "R5 R6 poll while busy");
    do_stop();
    wait_busy();
    do_start();
    send(8'hF0, exp_poll, "R6 poll after busy");
    if (!exp_poll) do_stop();
  endtask

  function automatic logic is_cmd(input logic [7:0] c);
    return (c == 8'h80) || (c == 8'h88) || (c == 8'h90) || (c == 8'h98) ||
           (c == 8'hA0) || (c == 8'hA8) || (c == 8'hB0) || (c == 8'hB8) ||
           (c == 8'hC0) || (c == 8'hE0) || (c == 8'hE8) || (c == 8'hF0);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [63:0] P, Q;
    int a;
    P = 64'h1122334455667788;
    Q = 64'h0102030405060708;
    for (int i = 0; i < D0; i++) m0[i] = '0;
    for (int i = 0; i < D1; i++) m1[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: quiet outputs, idle poll granted at once
    chk("R1 reset outputs", {14'd0, ack_valid, out_valid}, 16'd0);
    do_start();
    send(8'hF0, 1'b1, "R1 not busy after reset");
    do_stop();

    // R2: sweep of every first byte
    for (int c = 0; c < 256; c++) begin
      do_start();
      send(8'(c), is_cmd(8'(c)), "R2 command sweep");
      do_stop();
    end
    do_start();
    send(8'h81, 1'b0, "R2 illegal code");
    send(8'h80, 1'b0, "R2 standby after illegal");
    do_stop();

    // R8: sector write near the end of array 0, wrapping
    open_op(8'h90, 64'd0, 1'b1);
    send(8'h03, 1'b1, "R7 address high");
    send(8'hF0, 1'b1, "R7 address low");
    for (int i = 0; i < SEC; i++) begin
      send(8'((i * 7 + 3) & 255), 1'b1, "R8 sector byte");
      m0[(16'h3F0 + i) % D0] = 8'((i * 7 + 3) & 255);
    end
    send(8'hEE, 1'b0, "R8 byte beyond sector");
    do_stop();
    do_start();
    send(8'hF0, 1'b0, "R8 write cycle busy");
    do_stop();
    wait_busy();
    do_start();
    send(8'hF0, 1'b1, "R8 write cycle done");
    do_stop();

    // R10 R11: sequential read with wrap and random low-byte jump
    open_op(8'h80, 64'd0, 1'b1);
    send(8'h03, 1'b1, "R7 address high");
    send(8'hF8, 1'b1, "R7 address low");
    for (int i = 0; i < 4; i++) rd(m0[16'h3F8 + i], "R10 sequential read");
    do_start();
    send(8'hF2, 1'b1, "R11 new low byte");
    a = 16'h3F2;
    for (int i = 0; i < 18; i++) begin
      rd(m0[a], "R10 R11 read across wrap");
      a = (a + 1) % D0;
    end
    do_stop();

    // R9: abandoned write and interrupted password
    open_op(8'h90, 64'd0, 1'b1);
    send(8'h00, 1'b1, "R7 address high");
    send(8'h40, 1'b1, "R7 address low");
    for (int i = 0; i < 3; i++) send(8'h5A, 1'b1, "R9 data before abort");
    do_start();
    send(8'hF0, 1'b1, "R9 no busy after abort");
    do_stop();
    do_start();
    send(8'h80, 1'b1, "R9 command");
    for (int i = 0; i < 3; i++) send(8'h00, 1'b1, "R9 partial password");
    do_stop();
    do_start();
    send(8'hF0, 1'b1, "R9 no busy after partial password");
    do_stop();
    open_op(8'h80, 64'd0, 1'b1);
    send(8'h00, 1'b1, "R7 address high");
    send(8'h40, 1'b1, "R7 address low");
    for (int i = 0; i < 3; i++) rd(m0[16'h40 + i], "R9 aborted data absent");
    do_stop();

    // R10: array 1 write and read with wrap
    open_op(8'h98, 64'd0, 1'b1);
    send(8'h00, 1'b1, "R7 address high");
    send(8'h1C, 1'b1, "R7 address low");
    for (int i = 0; i < 8; i++) begin
      send(8'hA0 + 8'(i), 1'b1, "R8 array1 byte");
      m1[(28 + i) % D1] = 8'hA0 + 8'(i);
    end
    do_stop();
    wait_busy();
    open_op(8'h88, 64'd0, 1'b1);
    send(8'h00, 1'b1, "R7 address high");
    send(8'h1E, 1'b1, "R7 address low");
    a = 30;
    for (int i = 0; i < 6; i++) begin
      rd(m1[a], "R10 array1 wrap");
      a = (a + 1) % D1;
    end
    do_start();
    send(8'h21, 1'b1, "R11 array1 address");
    rd(m1[1], "R11 array1 random read");
    do_stop();

    // R12: change read password 0 to P
    open_op(8'hA0, 64'd0, 1'b1);
    send(8'h00, 1'b1, "R12 zero byte");
    send(8'h00, 1'b1, "R12 zero byte");
    send_pw(P, "R12 first copy");
    send_pw(P, "R12 second copy");
    do_stop();
    do_start();
    send(8'hF0, 1'b0, "R12 store busy");
    do_stop();
    wait_busy();
    open_op(8'h80, 64'd0, 1'b0);
    open_op(8'h80, P, 1'b1);
    send(8'h00, 1'b1, "R7 address high");
    send(8'h00, 1'b1, "R7 address low");
    rd(m0[0], "R12 read with new password");
    do_stop();

    // R12: mismatching copies leave P in place
    open_op(8'hA0, P, 1'b1);
    send(8'h00, 1'b1, "R12 zero byte");
    send(8'h00, 1'b1, "R12 zero byte");
    send_pw(Q, "R12 first copy");
    send_pw(Q ^ 64'h1, "R12 second copy");
    do_stop();
    do_start();
    send(8'hF0, 1'b1, "R12 mismatch starts no busy");
    do_stop();
    open_op(8'h80, P, 1'b1);
    do_stop();

    // R13: device reset changes nothing, clear-all wipes everything
    open_op(8'hE8, 64'd0, 1'b1);
    do_stop();
    open_op(8'h80, P, 1'b1);
    do_stop();
    open_op(8'hE0, 64'd0, 1'b1);
    do_stop();
    open_op(8'h80, 64'd0, 1'b1);
    send(8'h03, 1'b1, "R7 address high");
    send(8'hF0, 1'b1, "R7 address low");
    rd(8'h00, "R13 array0 cleared");
    rd(8'h00, "R13 array0 cleared");
    do_stop();
    open_op(8'h88, 64'd0, 1'b1);
    send(8'h00, 1'b1, "R7 address high");
    send(8'h1C, 1'b1, "R7 address low");
    rd(8'h00, "R13 array1 cleared");
    do_stop();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule